// File: doc/BRIEF.md
# CAN Controller Interrupt Identification Register

This block holds the interrupt flags that a CAN controller raises towards its host CPU. It samples the controller's status lines every clock, detects five kinds of event (a received message, a released transmit buffer, a change of error or bus state, an overrun of the receive buffers and a wake-up from sleep), and records each one in a sticky flag. Four of the flags are gated by their own enable inputs. The wake-up flag has no enable.

The host sees the flags as one read-only byte at a fixed address. It reads the byte, decodes which sources fired and handles them. The read also clears every flag, so no separate acknowledge write is needed. A single interrupt request line stays high as long as any flag is set. A flag whose event arrives in the same clock as the clearing read survives the read, so no event is lost.

Top module: `can_irq_status`

## Requirements
- R1: A read (`rd_en` high, `addr` = 3) returns on `rd_data` the flags {wake-up, overrun, error, transmit, receive} in bits 4..0. Bits 7..5 read as 0. While no read of address 3 is in progress, `rd_data` is 0.
- R2: `irq` is high exactly when at least one flag is set.
- R3: A read of address 3 clears all flags at the clock edge that ends the read. The data returned is the flag state before the clear.
- R4: Writes and reads to any address other than 3 leave the flags unchanged.
- R5: The wake-up flag (bit 4) is set when `sleep_mode` goes from 1 to 0. It needs no enable.
- R6: The overrun flag (bit 3) is set when `ovr_en` is high, `rx_bufs_full` is high and `rx_accept_first` is high in the same cycle.
- R7: The error flag (bit 2) is set when `err_en` is high and either `err_status` or `bus_status` differs from its value in the previous clock, in either direction.
- R8: The transmit flag (bit 1) is set when `tx_en` is high and `tx_buf_access` rises from 0 to 1. A fall from 1 to 0 does not set it.
- R9: The receive flag (bit 0) is set when `rx_en` is high and `rx_new_msg` is high.
- R10: While its enable is low, an event leaves the overrun, error, transmit or receive flag clear.
- R11: A set event in the same clock as a clearing read leaves that flag set after the read.
- R12: Asserting `rst_n` low clears all flags and all stored copies of the status inputs, so `irq` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | CPU register address |
| rd_en | input | 1 | CPU read strobe |
| wr_en | input | 1 | CPU write strobe (has no effect on this register) |
| wr_data | input | 8 | CPU write data (ignored) |
| rd_data | output | 8 | CPU read data |
| sleep_mode | input | 1 | Controller is in sleep mode |
| err_status | input | 1 | Error status bit |
| bus_status | input | 1 | Bus status bit |
| tx_buf_access | input | 1 | Transmit buffer released to the CPU |
| rx_new_msg | input | 1 | A new message became available this cycle |
| rx_bufs_full | input | 1 | Both receive buffers hold a message |
| rx_accept_first | input | 1 | First byte of an accepted message must be stored |
| rx_en | input | 1 | Receive interrupt enable |
| tx_en | input | 1 | Transmit interrupt enable |
| err_en | input | 1 | Error interrupt enable |
| ovr_en | input | 1 | Overrun interrupt enable |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The assertions check on every cycle that a clearing read with no coinciding event leaves no flag set, and that any detected event is present in the flags one cycle later. They also check that the flags hold still when there is neither a read nor an event, that the reserved bits read as 0, and that a falling transmit-access line never fires the transmit detector. Other behaviour can only be shown by the bench's scenarios. This covers the edge polarity of each detector, the effect of each enable, wake-up on leaving sleep, overrun only with both buffers full, the pre-clear value returned by a read, immunity to writes and to other addresses, and the asynchronous reset.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned DATA_W  = 8;

  localparam int unsigned BIT_RX   = 0;
  localparam int unsigned BIT_TX   = 1;
  localparam int unsigned BIT_ERR  = 2;
  localparam int unsigned BIT_OVR  = 3;
  localparam int unsigned BIT_WAKE = 4;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/can_irq_event_detect.sv
module can_irq_event_detect
  import can_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sleep_mode,
  input  logic     err_status,
  input  logic     bus_status,
  input  logic     tx_buf_access,
  input  logic     rx_new_msg,
  input  logic     rx_bufs_full,
  input  logic     rx_accept_first,
  input  logic     rx_en,
  input  logic     tx_en,
  input  logic     err_en,
  input  logic     ovr_en,
  output src_vec_t set_ev
);
  localparam int unsigned HIST_W = 4;

  logic [HIST_W-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = {sleep_mode, err_status, bus_status, tx_buf_access};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  logic sleep_prev, err_prev, bus_prev, tx_prev;
  assign {sleep_prev, err_prev, bus_prev, tx_prev} = hist_q;

  always_comb begin
    set_ev           = '0;
    set_ev[BIT_RX]   = rx_en & rx_new_msg;
    set_ev[BIT_TX]   = tx_en & tx_buf_access & ~tx_prev;
    set_ev[BIT_ERR]  = err_en & ((err_status ^ err_prev) | (bus_status ^ bus_prev));
    set_ev[BIT_OVR]  = ovr_en & rx_bufs_full & rx_accept_first;
    set_ev[BIT_WAKE] = sleep_prev & ~sleep_mode;
  end

  // R8
  tx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_buf_access) |-> !set_ev[BIT_TX]);

  // R10
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !set_ev[BIT_RX]);
endmodule

// File: rtl/can_irq_flag_bank.sv
module can_irq_flag_bank
  import can_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  src_vec_t set_ev,
  output src_vec_t flag_q
);
  src_vec_t flag_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_comb begin
      flag_d[i] = (flag_q[i] & ~clr) | set_ev[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_ev == '0) |=> flag_q == '0);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev != '0) |=> ((flag_q & $past(set_ev)) == $past(set_ev)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && set_ev == '0) |=> $stable(flag_q));
endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
  import can_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sleep_mode,
  input  logic              err_status,
  input  logic              bus_status,
  input  logic              tx_buf_access,
  input  logic              rx_new_msg,
  input  logic              rx_bufs_full,
  input  logic              rx_accept_first,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              err_en,
  input  logic              ovr_en,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

  src_vec_t set_ev;
  src_vec_t flag_q;
  logic     rd_hit;
  logic     wr_unused;

  assign rd_hit    = rd_en & (addr == SEL_ADDR);
  assign wr_unused = wr_en ^ (^wr_data);

  can_irq_event_detect u_detect (
    .clk             (clk),
    .rst_n           (rst_n),
    .sleep_mode      (sleep_mode),
    .err_status      (err_status),
    .bus_status      (bus_status),
    .tx_buf_access   (tx_buf_access),
    .rx_new_msg      (rx_new_msg),
    .rx_bufs_full    (rx_bufs_full),
    .rx_accept_first (rx_accept_first),
    .rx_en           (rx_en),
    .tx_en           (tx_en),
    .err_en          (err_en),
    .ovr_en          (ovr_en),
    .set_ev          (set_ev)
  );

  can_irq_flag_bank u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (rd_hit),
    .set_ev (set_ev),
    .flag_q (flag_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data = {{PAD_W{1'b0}}, flag_q};
  end

  assign irq = |flag_q;

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:NUM_SRC] == '0);

  // R2
  quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !irq) |-> rd_data == '0);

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == '0);
endmodule

// File: tb/can_irq_status_test.sv
`timescale 1ns/1ps
module can_irq_status_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       rd_en, wr_en;
  logic [7:0] wr_data, rd_data;
  logic       sleep_mode, err_status, bus_status, tx_buf_access;
  logic       rx_new_msg, rx_bufs_full, rx_accept_first;
  logic       rx_en, tx_en, err_en, ovr_en;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  can_irq_status uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sleep_mode(sleep_mode),
    .err_status(err_status), .bus_status(bus_status),
    .tx_buf_access(tx_buf_access), .rx_new_msg(rx_new_msg),
    .rx_bufs_full(rx_bufs_full), .rx_accept_first(rx_accept_first),
    .rx_en(rx_en), .tx_en(tx_en), .err_en(err_en), .ovr_en(ovr_en),
    .irq(irq)
  );

  // {rd, en(ovr,err,tx,rx), sleep, err, bus, tx, rxnew, full, acc, exp_rd[4:0], exp_irq}
  localparam int NV = 25;
  localparam logic [17:0] VEC [NV] = '{
    18'b1_1111_0000000_00000_0, // R12 start: all clear
    18'b0_1111_0000100_00000_1, // R9 new message
    18'b1_1111_0000000_00001_0, // R3 read rx
    18'b0_1111_0001000_00000_1, // R8 tx rise
    18'b1_1111_0001000_00010_0, // R3 read tx
    18'b0_1111_0000000_00000_0, // R8 tx fall
    18'b1_1111_0000000_00000_0, // R8 fall set nothing
    18'b0_1111_0100000_00000_1, // R7 err rise
    18'b1_1111_0100000_00100_0,
    18'b0_1111_0000000_00000_1, // R7 err fall
    18'b1_1111_0000000_00100_0,
    18'b0_1111_0010000_00000_1, // R7 bus rise
    18'b1_1111_0010000_00100_0,
    18'b0_1111_1010000_00000_0, // R5 enter sleep
    18'b0_1111_0010000_00000_1, // R5 leave sleep
    18'b1_1111_0010000_10000_0,
    18'b0_1111_0010011_00000_1, // R6 overrun
    18'b1_1111_0010010_01000_0,
    18'b0_1111_0010001_00000_0, // R6 not full
    18'b1_1111_0010000_00000_0,
    18'b0_0000_0111111_00000_0, // R10 all disabled
    18'b1_0000_0010000_00000_0, // R10 read empty
    18'b0_1111_0011100_00000_1, // R9 R8 together
    18'b1_1111_0011100_00011_1, // R11 rx during read
    18'b1_1111_0011000_00001_0  // R11 survived
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    addr = 4'd3; rd_en = 0; wr_en = 0; wr_data = 8'h00;
    rx_new_msg = 0; rx_accept_first = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    sleep_mode = 0; err_status = 0; bus_status = 0; tx_buf_access = 0;
    rx_bufs_full = 0; rx_en = 1; tx_en = 1; err_en = 1; ovr_en = 1;
    repeat (3) @(negedge clk);
    chk("R12 irq in reset", {7'd0, irq}, 8'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rd_en, ovr_en, err_en, tx_en, rx_en, sleep_mode, err_status, bus_status,
       tx_buf_access, rx_new_msg, rx_bufs_full, rx_accept_first} = VEC[i][17:6];
      addr = 4'd3;
      #1;
      chk($sformatf("R1 R3 vector %0d rd_data", i), rd_data, {3'b000, VEC[i][5:1]});
      @(posedge clk);
      #1;
      chk($sformatf("R2 vector %0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R4: write to the register and read another address
    @(negedge clk);
    idle_inputs(); rx_new_msg = 1;
    @(negedge clk);
    rx_new_msg = 0; wr_en = 1; wr_data = 8'hFF; addr = 4'd3;
    @(negedge clk);
    wr_en = 0; rd_en = 1; addr = 4'd2;
    #1 chk("R4 other address reads 0", rd_data, 8'h00);
    @(negedge clk);
    chk("R4 irq kept", {7'd0, irq}, 8'd1);
    addr = 4'd3;
    #1 chk("R4 flag kept", rd_data, 8'h01);
    @(negedge clk);
    rd_en = 0;

    // R12: asynchronous reset mid-run
    rx_new_msg = 1;
    @(negedge clk);
    rx_new_msg = 0;
    chk("R12 flag before reset", {7'd0, irq}, 8'd1);
    #1 rst_n = 0;
    #0.5 chk("R12 irq cleared", {7'd0, irq}, 8'd0);
    @(negedge clk);
    rst_n = 1; bus_status = 0; tx_buf_access = 0; sleep_mode = 0;
    rd_en = 1;
    #1 chk("R12 flags read 0", rd_data, 8'h00);
    @(negedge clk);
    rd_en = 0;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule